// File: doc/BRIEF.md
# Micro-op Loop Buffer

This block sits between the micro-op supplier of a core frontend (decoders or op cache) and the rename stage. In normal operation it is a transparent pipe: every micro-op offered upstream passes straight through and the supplier sees the downstream ready signal directly. Meanwhile it watches the stream for a short loop. A taken branch whose target is below its own address opens a capture. From the next accepted micro-op on, the body is recorded into a small local store. When that same branch is seen again, taken to the same target, the loop is locked.

Once locked, the block stops accepting upstream micro-ops and delivers the stored body from its own store. It delivers one micro-op per cycle, starting from the first recorded entry and wrapping after the closing branch. It also raises an idle signal so that the upstream fetch and decode stages can be gated off.

A redirect ends replay and empties the store. So do a cleared enable bit and a change of the two-thread mode. A body containing a call or return is never locked. A body larger than the capacity is never locked either: the full store in single-thread mode, or half of it when two threads share the core.

Top module: `uop_loop_buffer`

## Requirements
- R1: While not replaying, the outputs mirror the inputs: out_valid_o equals in_valid_i, out_uop_o/out_pc_o/out_taken_o/out_tgt_o/out_callret_o equal the input fields, in_ready_o equals out_ready_i, and idle_o is 0.
- R2: Capture starts only on an accepted taken micro-op with in_tgt_i strictly less than in_pc_i; a taken forward branch never leads to a lock.
- R3: In the cycle after the accepted closing branch (same address, taken, same target as the opener), idle_o is 1, in_ready_o is 0, out_valid_o is 1, and out_pc_o/out_uop_o show the first recorded micro-op. Each cycle with out_ready_i high advances to the next entry, wrapping to the first after the closing branch. With out_ready_i low the output holds.
- R4: An accepted call/return micro-op (in_callret_i = 1) during capture abandons it; the loop is not locked.
- R5: In single-thread mode (smt_i = 0) a body of up to DEPTH = 144 micro-ops, closing branch included, locks; a body of 145 does not.
- R6: In two-thread mode (smt_i = 1) a body of up to DEPTH/2 = 72 micro-ops locks; a body of 73 does not.
- R7: With en_i = 0 nothing is captured and idle_o stays 0; clearing en_i during replay returns the block to pass-through one cycle later.
- R8: flush_i ends replay one cycle later and empties the store: a single later pass through the body does not lock, and a second one is needed.
- R9: A change of smt_i during capture or replay abandons it; during replay pass-through resumes one cycle later.
- R10: If the closing branch's address shows up not taken or with a different target during capture, the capture is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Feature enable; 0 forces pass-through |
| smt_i | input | 1 | Two-thread mode; halves the usable capacity |
| flush_i | input | 1 | Redirect or flush; ends replay and empties the store |
| in_valid_i | input | 1 | Upstream micro-op valid |
| in_ready_o | output | 1 | Upstream may hand over a micro-op |
| in_uop_i | input | UOP_W | Upstream micro-op payload |
| in_pc_i | input | PC_W | Address tag of the upstream micro-op |
| in_taken_i | input | 1 | Micro-op is a taken branch |
| in_tgt_i | input | PC_W | Branch target address |
| in_callret_i | input | 1 | Micro-op is a call or return |
| out_valid_o | output | 1 | Micro-op toward rename valid |
| out_ready_i | input | 1 | Rename accepts a micro-op |
| out_uop_o | output | UOP_W | Micro-op payload toward rename |
| out_pc_o | output | PC_W | Address tag toward rename |
| out_taken_o | output | 1 | Taken-branch flag toward rename |
| out_tgt_o | output | PC_W | Branch target toward rename |
| out_callret_o | output | 1 | Call/return flag toward rename |
| idle_o | output | 1 | Upstream fetch and decode may idle (replay active) |

## Verification
Pass-through results are combinational, so the bench drives each micro-op at a falling edge and compares outputs 1 ns later, in the same cycle. Lock, abort and kill results are registered. They appear after the next rising edge, so the bench samples them at the following falling edge: replay entry 0 and idle_o one edge after the closing branch, and pass-through one edge after flush, a cleared enable or a mode change. During replay, the expected entry index is advanced in the bench only across edges where it held out_ready_i high. The index is computed modulo the body length from the known addresses.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    ST_MON = 2'd0,
    ST_CAP = 2'd1,
    ST_REP = 2'd2
  } lb_state_e;
endpackage

// File: rtl/lb_store.sv
module lb_store #(
  parameter int DEPTH = 144,
  parameter int W     = 8
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [W-1:0]             rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == AW'(i)) mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
#(
  parameter int DEPTH = 144,
  parameter int PC_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     smt_i,
  input  logic                     flush_i,
  input  logic                     acc_i,
  input  logic [PC_W-1:0]          pc_i,
  input  logic                     taken_i,
  input  logic [PC_W-1:0]          tgt_i,
  input  logic                     callret_i,
  input  logic                     fire_i,
  output lb_state_e                state_o,
  output logic                     wr_en_o,
  output logic [$clog2(DEPTH)-1:0] wr_addr_o,
  output logic [$clog2(DEPTH)-1:0] rd_addr_o
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;

  lb_state_e       st_q;
  logic [CW-1:0]   cnt_q, len_q, cap;
  logic [AW-1:0]   rd_q;
  logic [PC_W-1:0] br_pc_q, br_tgt_q;
  logic            smt_q;
  logic            hold_off, mode_chg, is_close, close_ok, backward;

  assign cap      = smt_i ? CW'(HALF) : CW'(DEPTH);
  assign hold_off = flush_i || !en_i;
  assign mode_chg = smt_i != smt_q;
  assign is_close = pc_i == br_pc_q;
  assign close_ok = is_close && taken_i && tgt_i == br_tgt_q;
  assign backward = taken_i && (tgt_i < pc_i);

  assign wr_en_o   = st_q == ST_CAP && !hold_off && !mode_chg && acc_i && !callret_i
                     && cnt_q < cap && (!is_close || close_ok);
  assign wr_addr_o = AW'(cnt_q);
  assign rd_addr_o = rd_q;
  assign state_o   = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_MON;
      cnt_q    <= '0;
      len_q    <= '0;
      rd_q     <= '0;
      br_pc_q  <= '0;
      br_tgt_q <= '0;
      smt_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_MON: begin
          if (!hold_off && acc_i && backward) begin
            st_q     <= ST_CAP;
            br_pc_q  <= pc_i;
            br_tgt_q <= tgt_i;
            cnt_q    <= '0;
            smt_q    <= smt_i;
          end
        end
        ST_CAP: begin
          if (hold_off || mode_chg) begin
            st_q  <= ST_MON;
            cnt_q <= '0;
          end else if (acc_i) begin
            if (callret_i || cnt_q >= cap || (is_close && !close_ok)) begin
              st_q  <= ST_MON;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (close_ok) begin
                st_q  <= ST_REP;
                len_q <= cnt_q + 1'b1;
                rd_q  <= '0;
              end
            end
          end
        end
        ST_REP: begin
          if (hold_off || mode_chg) begin
            st_q  <= ST_MON;
            cnt_q <= '0;
            len_q <= '0;
            rd_q  <= '0;
          end else if (fire_i) begin
            rd_q <= (CW'(rd_q) == len_q - 1'b1) ? '0 : rd_q + 1'b1;
          end
        end
        default: st_q <= ST_MON;
      endcase
    end
  end

  p_cap_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CAP && !smt_q) |-> cnt_q <= CW'(DEPTH));
  p_cap_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_MON && smt_q) |-> (cnt_q <= CW'(HALF) && len_q <= CW'(HALF)));
  p_rd_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_REP |-> CW'(rd_q) < len_q);
  p_no_callret_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CAP && acc_i && callret_i) |=> st_q != ST_REP);
  p_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> st_q == ST_MON);
  p_flush_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (st_q == ST_MON && len_q == '0));
  p_mode_kill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REP && smt_i != smt_q) |=> st_q == ST_MON);
endmodule

// File: rtl/uop_loop_buffer.sv
module uop_loop_buffer
  import lb_pkg::*;
#(
  parameter int DEPTH = 144,
  parameter int UOP_W = 32,
  parameter int PC_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             smt_i,
  input  logic             flush_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [UOP_W-1:0] in_uop_i,
  input  logic [PC_W-1:0]  in_pc_i,
  input  logic             in_taken_i,
  input  logic [PC_W-1:0]  in_tgt_i,
  input  logic             in_callret_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [UOP_W-1:0] out_uop_o,
  output logic [PC_W-1:0]  out_pc_o,
  output logic             out_taken_o,
  output logic [PC_W-1:0]  out_tgt_o,
  output logic             out_callret_o,
  output logic             idle_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = UOP_W + 2 * PC_W + 1;

  lb_state_e       state;
  logic            rep, acc, fire, we;
  logic [AW-1:0]   waddr, raddr;
  logic [EW-1:0]   wdata, rdata;
  logic [UOP_W-1:0] r_uop;
  logic [PC_W-1:0] r_pc, r_tgt;
  logic            r_taken;

  assign rep  = state == ST_REP;
  assign acc  = in_valid_i && out_ready_i && !rep;
  assign fire = rep && out_ready_i;

  lb_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .smt_i     (smt_i),
    .flush_i   (flush_i),
    .acc_i     (acc),
    .pc_i      (in_pc_i),
    .taken_i   (in_taken_i),
    .tgt_i     (in_tgt_i),
    .callret_i (in_callret_i),
    .fire_i    (fire),
    .state_o   (state),
    .wr_en_o   (we),
    .wr_addr_o (waddr),
    .rd_addr_o (raddr)
  );

  assign wdata = {in_uop_i, in_pc_i, in_tgt_i, in_taken_i};

  lb_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign {r_uop, r_pc, r_tgt, r_taken} = rdata;

  assign in_ready_o    = rep ? 1'b0 : out_ready_i;
  assign out_valid_o   = rep | in_valid_i;
  assign out_uop_o     = rep ? r_uop   : in_uop_i;
  assign out_pc_o      = rep ? r_pc    : in_pc_i;
  assign out_taken_o   = rep ? r_taken : in_taken_i;
  assign out_tgt_o     = rep ? r_tgt   : in_tgt_i;
  assign out_callret_o = rep ? 1'b0    : in_callret_i;
  assign idle_o        = rep;

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!in_ready_o && out_valid_o && !out_callret_o));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !out_ready_i && !flush_i && en_i && !$changed(smt_i)) |=>
      (!idle_o || $stable(out_pc_o)));
  p_off_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !idle_o);
endmodule

// File: tb/tb_uop_loop_buffer.sv
module tb_uop_loop_buffer;
  localparam int DEPTH = 144;
  localparam int UOP_W = 32;
  localparam int PC_W  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en, smt, flush;
  logic in_valid, in_ready, in_taken, in_callret;
  logic [UOP_W-1:0] in_uop, out_uop;
  logic [PC_W-1:0] in_pc, in_tgt, out_pc, out_tgt;
  logic out_valid, out_ready, out_taken, out_callret, idle;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  uop_loop_buffer #(.DEPTH(DEPTH), .UOP_W(UOP_W), .PC_W(PC_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .smt_i(smt), .flush_i(flush),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_uop_i(in_uop),
    .in_pc_i(in_pc), .in_taken_i(in_taken), .in_tgt_i(in_tgt),
    .in_callret_i(in_callret), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_uop_o(out_uop), .out_pc_o(out_pc), .out_taken_o(out_taken),
    .out_tgt_o(out_tgt), .out_callret_o(out_callret), .idle_o(idle)
  );

  function automatic logic [UOP_W-1:0] uop_of(input logic [PC_W-1:0] pc);
    return {pc ^ 16'h5A5A, pc};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one upstream micro-op, pass-through checked in the same cycle (R1)
  task automatic drive(input logic [PC_W-1:0] pc, input logic tk,
                       input logic [PC_W-1:0] tg, input logic cr);
    in_valid = 1'b1; in_pc = pc; in_taken = tk; in_tgt = tg;
    in_callret = cr; in_uop = uop_of(pc);
    #1;
    chk("R1", "pass valid", 64'(out_valid), 64'd1);
    chk("R1", "pass pc", 64'(out_pc), 64'(pc));
    chk("R1", "pass uop", 64'(out_uop), 64'(uop_of(pc)));
    chk("R1", "pass tgt", 64'(out_tgt), 64'(tg));
    chk("R1", "pass callret", 64'(out_callret), 64'(cr));
    chk("R1", "in_ready", 64'(in_ready), 64'(out_ready));
    chk("R1", "idle low", 64'(idle), 64'd0);
    next_cyc();
    in_valid = 1'b0; in_taken = 1'b0; in_callret = 1'b0;
  endtask

  task automatic body(input logic [PC_W-1:0] base, input int n, input int cr_at);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) drive(base + PC_W'(i), 1'b1, base, 1'b0);
      else drive(base + PC_W'(i), 1'b0, '0, i == cr_at);
    end
  endtask

  task automatic expect_idle(input string req, input logic exp);
    #1;
    chk(req, "idle", 64'(idle), 64'(exp));
  endtask

  task automatic replay(input logic [PC_W-1:0] base, input int n, input int cycles,
                        input string req);
    int idx = 0;
    for (int k = 0; k < cycles; k++) begin
      out_ready = (k % 4) != 3;
      #1;
      chk(req, "rep valid", 64'(out_valid), 64'd1);
      chk(req, "rep idle", 64'(idle), 64'd1);
      chk(req, "rep in_ready", 64'(in_ready), 64'd0);
      chk(req, "rep pc", 64'(out_pc), 64'(base + PC_W'(idx)));
      chk(req, "rep uop", 64'(out_uop), 64'(uop_of(base + PC_W'(idx))));
      chk(req, "rep taken", 64'(out_taken), 64'(idx == n - 1));
      next_cyc();
      if (out_ready) idx = (idx + 1) % n;
    end
    out_ready = 1'b1;
  endtask

  task automatic flush_pulse(input string req);
    flush = 1'b1;
    next_cyc();
    flush = 1'b0;
    #1;
    chk(req, "after flush idle", 64'(idle), 64'd0);
    chk(req, "after flush valid", 64'(out_valid), 64'(in_valid));
  endtask

  task automatic trial(input logic [PC_W-1:0] base, input int n, input logic lock,
                       input string req);
    drive(base + PC_W'(n - 1), 1'b1, base, 1'b0);
    body(base, n, -1);
    expect_idle(req, lock);
    if (lock) replay(base, n, 2 * n + 3, "R3");
    flush_pulse("R8");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; smt = 1'b0; flush = 1'b0; out_ready = 1'b1;
    in_valid = 1'b0; in_pc = '0; in_tgt = '0; in_taken = 1'b0;
    in_callret = 1'b0; in_uop = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "reset idle", 64'(idle), 64'd0);
    chk("R1", "reset valid", 64'(out_valid), 64'd0);
    chk("R1", "reset in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);

    // R5: single-thread size sweep, 145 overflows
    for (int n = 2; n <= DEPTH + 1; n++) trial(16'h1000, n, n <= DEPTH, "R5");

    // R6: two-thread sweep, limit is half
    smt = 1'b1;
    for (int n = 2; n <= DEPTH / 2 + 1; n++) trial(16'h2000, n, n <= DEPTH / 2, "R6");
    smt = 1'b0;

    // R4: call/return inside the body
    drive(16'h3009, 1'b1, 16'h3000, 1'b0);
    body(16'h3000, 10, 4);
    expect_idle("R4", 1'b0);
    flush_pulse("R8");

    // R2: taken forward branch closing a stretch twice never locks
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 4; i++)
        drive(16'h4000 + PC_W'(i), i == 3, (i == 3) ? 16'h4010 : 16'h0, 1'b0);
    expect_idle("R2", 1'b0);
    flush_pulse("R8");

    // R10: closing address not taken, then wrong target
    drive(16'h5005, 1'b1, 16'h5000, 1'b0);
    for (int i = 0; i < 6; i++) drive(16'h5000 + PC_W'(i), 1'b0, '0, 1'b0);
    expect_idle("R10", 1'b0);
    flush_pulse("R8");
    drive(16'h5005, 1'b1, 16'h5000, 1'b0);
    for (int i = 0; i < 5; i++) drive(16'h5000 + PC_W'(i), 1'b0, '0, 1'b0);
    drive(16'h5005, 1'b1, 16'h5001, 1'b0);
    expect_idle("R10", 1'b0);
    flush_pulse("R8");

    // R7: disabled, two full passes never lock
    en = 1'b0;
    drive(16'h6005, 1'b1, 16'h6000, 1'b0);
    body(16'h6000, 6, -1);
    body(16'h6000, 6, -1);
    expect_idle("R7", 1'b0);
    en = 1'b1;
    flush_pulse("R8");

    // R7: enable cleared during replay
    drive(16'h6005, 1'b1, 16'h6000, 1'b0);
    body(16'h6000, 6, -1);
    replay(16'h6000, 6, 5, "R3");
    en = 1'b0;
    next_cyc();
    expect_idle("R7", 1'b0);
    chk("R7", "pass valid", 64'(out_valid), 64'(in_valid));
    chk("R7", "in_ready", 64'(in_ready), 64'(out_ready));
    en = 1'b1;
    flush_pulse("R8");

    // R9: mode change during replay
    drive(16'h7003, 1'b1, 16'h7000, 1'b0);
    body(16'h7000, 4, -1);
    replay(16'h7000, 4, 3, "R3");
    smt = 1'b1;
    next_cyc();
    expect_idle("R9", 1'b0);
    smt = 1'b0;
    flush_pulse("R8");

    // R9: mode change during capture
    drive(16'h7007, 1'b1, 16'h7000, 1'b0);
    for (int i = 0; i < 3; i++) drive(16'h7000 + PC_W'(i), 1'b0, '0, 1'b0);
    smt = 1'b1;
    for (int i = 3; i < 7; i++) drive(16'h7000 + PC_W'(i), 1'b0, '0, 1'b0);
    drive(16'h7007, 1'b1, 16'h7000, 1'b0);
    expect_idle("R9", 1'b0);
    smt = 1'b0;
    flush_pulse("R8");

    // R8: flush empties the store, one pass is not enough afterwards
    drive(16'h8004, 1'b1, 16'h8000, 1'b0);
    body(16'h8000, 5, -1);
    replay(16'h8000, 5, 7, "R3");
    flush_pulse("R8");
    body(16'h8000, 5, -1);
    expect_idle("R8", 1'b0);
    body(16'h8000, 5, -1);
    expect_idle("R8", 1'b1);
    replay(16'h8000, 5, 12, "R3");
    flush_pulse("R8");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule